// File: doc/BRIEF.md
# Soft-Switching Gate Drive Sequencer

This block converts a logic-level on/off command into a three-level selection for a power-switch gate driver: off, a reduced "clamp" plateau, and full drive. Each turn-on passes through the plateau for a fixed number of cycles before full drive is applied, which limits inrush current. A desaturation indication from the power stage is masked for a blanking window that starts with every turn-on. After that window, a desaturation event steps the drive back to the plateau for a fault interval. If the event is gone at the end of that interval, full drive resumes. If it is still present, the drive is switched off and new turn-on commands are refused for a lock-off interval. A fault reply flag, active high, is raised for the whole fault interval and for the whole lock-off interval.

An active-low enable and an undervoltage flag both force the drive off. The desaturation, enable and undervoltage inputs are asynchronous to the controller clock, so each passes through a two-flop synchronizer. All interfaces are plain level signals; there is no streamed data and no handshake. Every timing value is a parameter counted in clock cycles.

Top module: `gdrv_sequencer`

## Requirements
- R1: `drive_lvl` uses the codes 00 = off, 01 = clamp plateau and 10 = full drive, and never shows 11. After reset the block shows 00 with `fault_reply` low.
- R2: When `cmd_on` rises while the block is idle and not inhibited, `drive_lvl` shows 01 for exactly `TP_CYC` cycles, starting one cycle after the command, and then shows 10.
- R3: While the block counts the first `TB_CYC` cycles after a turn-on begins, desaturation is ignored. The drive continues to 10 as in R2.
- R4: While the drive is at 10 and blanking has ended, a `desat` input that goes high puts `drive_lvl` at 01 and `fault_reply` high three cycles later. Two of those cycles are synchronizer delay. The full drive code 10 never appears while `fault_reply` is high.
- R5: When the synchronized desaturation input is low at the last of the `TF_CYC` fault cycles, `drive_lvl` returns to 10 and `fault_reply` goes low in the next cycle.
- R6: When the synchronized desaturation input is still high at the last fault cycle, `drive_lvl` goes to 00 and `fault_reply` stays high for `LOCK_CYC` cycles. During those cycles `cmd_on` is ignored. In the cycle after lock-off ends, `fault_reply` is low. If `cmd_on` is then high, a fresh plateau starts one cycle later.
- R7: Outside lock-off, `cmd_on` low forces `drive_lvl` to 00 in the next cycle. This cancels any plateau or fault interval in progress, and `fault_reply` drops with it.
- R8: `en_n` high forces `drive_lvl` to 00 three cycles later and holds it there whatever `cmd_on` does. Three cycles after `en_n` returns low, a still-high `cmd_on` starts a fresh plateau.
- R9: `uvlo` high forces `drive_lvl` to 00 three cycles later, including during a fault interval. In that case `fault_reply` drops as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_on | input | 1 | Gate on/off command, synchronous to `clk` |
| en_n | input | 1 | Enable, active low, asynchronous |
| desat | input | 1 | Desaturation detected, asynchronous |
| uvlo | input | 1 | Supply undervoltage, asynchronous |
| drive_lvl | output | 2 | Drive level: 00 off, 01 clamp plateau, 10 full |
| fault_reply | output | 1 | High during a fault interval and during lock-off |

## Verification
A plain command pulse with no desaturation checks the plateau length and the immediate drop on command release. Desaturation held high from the turn-on command separates a correct blanking window from one that is one cycle short or one cycle long. Two patterns use a desaturation pulse after blanking: one clears within the fault interval and one does not, and together they tell the transient outcome from the persistent one. During lock-off the command is toggled, which shows that it is ignored until the exact cycle lock-off expires. Enable and undervoltage are applied during full drive and during a fault interval, which checks both the forced-off path and the restart after release.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PLAT  = 3'd1,
    ST_FULL  = 3'd2,
    ST_FAULT = 3'd3,
    ST_LOCK  = 3'd4
  } seq_state_t;

  typedef enum logic [1:0] {
    LVL_OFF   = 2'b00,
    LVL_CLAMP = 2'b01,
    LVL_FULL  = 2'b10
  } drive_code_t;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int unsigned        WIDTH   = 3,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[g] <= RST_VAL;
        end else if (g == 0) begin
          stage_q[g] <= async_in;
        end else begin
          stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gdrv_blank_timer.sv
module gdrv_blank_timer #(
  parameter int unsigned TB_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic expired
);

  localparam int unsigned CW = $clog2(TB_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(TB_CYC);
    end else if (restart) begin
      cnt_q <= '0;
    end else if (cnt_q != CW'(TB_CYC)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = (cnt_q == CW'(TB_CYC));

endmodule

// File: rtl/gdrv_phase_ctrl.sv
module gdrv_phase_ctrl
  import gdrv_pkg::*;
#(
  parameter int unsigned TP_CYC   = 3,
  parameter int unsigned TF_CYC   = 6,
  parameter int unsigned LOCK_CYC = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_on,
  input  logic       inhibit,
  input  logic       desat_s,
  input  logic       blank_done,
  output seq_state_t state,
  output logic       turn_on_start
);

  localparam int unsigned MAXC = max3(TP_CYC, TF_CYC, LOCK_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  seq_state_t    state_q, state_d;
  logic [CW-1:0] phase_q;
  logic          timed;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_on && !inhibit) state_d = ST_PLAT;
      end
      ST_PLAT: begin
        if (inhibit || !cmd_on)              state_d = ST_IDLE;
        else if (phase_q == CW'(TP_CYC - 1)) state_d = ST_FULL;
      end
      ST_FULL: begin
        if (inhibit || !cmd_on)          state_d = ST_IDLE;
        else if (desat_s && blank_done)  state_d = ST_FAULT;
      end
      ST_FAULT: begin
        if (inhibit || !cmd_on)              state_d = ST_IDLE;
        else if (phase_q == CW'(TF_CYC - 1)) state_d = desat_s ? ST_LOCK : ST_FULL;
      end
      ST_LOCK: begin
        if (phase_q == CW'(LOCK_CYC - 1)) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign timed = (state_q == ST_PLAT) || (state_q == ST_FAULT) || (state_q == ST_LOCK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q)  phase_q <= '0;
      else if (timed)          phase_q <= phase_q + 1'b1;
    end
  end

  assign state         = state_q;
  assign turn_on_start = (state_q == ST_IDLE) && (state_d == ST_PLAT);

endmodule

// File: rtl/gdrv_sequencer.sv
module gdrv_sequencer
  import gdrv_pkg::*;
#(
  parameter int unsigned TP_CYC    = 50,
  parameter int unsigned TB_CYC    = 250,
  parameter int unsigned TF_CYC    = 50,
  parameter int unsigned LOCK_CYC  = 1250,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_on,
  input  logic       en_n,
  input  logic       desat,
  input  logic       uvlo,
  output logic [1:0] drive_lvl,
  output logic       fault_reply
);

  localparam int unsigned NSYNC = 3;

  logic [NSYNC-1:0] raw_in, sync_in;
  logic             desat_s, en_n_s, uvlo_s, inhibit;
  logic             blank_done, turn_on_start;
  seq_state_t       state;
  drive_code_t      lvl;

  assign raw_in = {uvlo, en_n, desat};

  gdrv_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STG),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(raw_in),
    .sync_out(sync_in)
  );

  assign desat_s = sync_in[0];
  assign en_n_s  = sync_in[1];
  assign uvlo_s  = sync_in[2];
  assign inhibit = en_n_s | uvlo_s;

  gdrv_blank_timer #(
    .TB_CYC(TB_CYC)
  ) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(turn_on_start),
    .expired(blank_done)
  );

  gdrv_phase_ctrl #(
    .TP_CYC  (TP_CYC),
    .TF_CYC  (TF_CYC),
    .LOCK_CYC(LOCK_CYC)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_on       (cmd_on),
    .inhibit      (inhibit),
    .desat_s      (desat_s),
    .blank_done   (blank_done),
    .state        (state),
    .turn_on_start(turn_on_start)
  );

  always_comb begin
    unique case (state)
      ST_PLAT, ST_FAULT: lvl = LVL_CLAMP;
      ST_FULL:           lvl = LVL_FULL;
      default:           lvl = LVL_OFF;
    endcase
  end

  assign drive_lvl   = lvl;
  assign fault_reply = (state == ST_FAULT) || (state == ST_LOCK);

endmodule

// File: rtl/gdrv_sequencer_chk.sv
module gdrv_sequencer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_on,
  input logic       en_n,
  input logic       uvlo,
  input logic [1:0] drive_lvl,
  input logic       fault_reply
);

  a_r1_no_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    drive_lvl != 2'b11);

  a_r2_off_never_jumps_full: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_lvl == 2'b00) |=> (drive_lvl != 2'b10));

  a_r4_reply_excludes_full: assert property (@(posedge clk) disable iff (!rst_n)
    fault_reply |-> (drive_lvl != 2'b10));

  a_r7_cmd_low_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_on |=> (drive_lvl == 2'b00));

  // R9 shares this check: undervoltage and disable use the same forced-off path
  a_r8_inhibit_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_n, 3) || $past(uvlo, 3)) |-> (drive_lvl == 2'b00));

endmodule

bind gdrv_sequencer gdrv_sequencer_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_on     (cmd_on),
  .en_n       (en_n),
  .uvlo       (uvlo),
  .drive_lvl  (drive_lvl),
  .fault_reply(fault_reply)
);

// File: tb/gdrv_sequencer_bench.sv
module gdrv_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TP   = 3;
  localparam int TB   = 10;
  localparam int TF   = 6;
  localparam int LOCK = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_on = 1'b0, en_n = 1'b0, desat = 1'b0, uvlo = 1'b0;
  logic [1:0] drive_lvl;
  logic       fault_reply;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gdrv_sequencer #(
    .TP_CYC  (TP),
    .TB_CYC  (TB),
    .TF_CYC  (TF),
    .LOCK_CYC(LOCK)
  ) u_gdrv_sequencer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_on     (cmd_on),
    .en_n       (en_n),
    .desat      (desat),
    .uvlo       (uvlo),
    .drive_lvl  (drive_lvl),
    .fault_reply(fault_reply)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] exp_lvl, input logic exp_rep);
    checks++;
    if (drive_lvl !== exp_lvl || fault_reply !== exp_rep) begin
      failures++;
      $display("FAIL %s: lvl=%b reply=%b expected lvl=%b reply=%b at %0t",
               req, drive_lvl, fault_reply, exp_lvl, exp_rep, $time);
    end
  endtask

  task automatic settle_off();
    cmd_on = 1'b0; desat = 1'b0; en_n = 1'b0; uvlo = 1'b0;
    step(4);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(3);
    chk("R1 in reset", 2'b00, 1'b0);
    rst_n = 1'b1;
    step(4);
    chk("R1 after reset", 2'b00, 1'b0);
  endtask

  task automatic t_turn_on();
    cmd_on = 1'b1;
    for (int i = 0; i < TP; i++) begin
      step(1);
      chk("R2 plateau", 2'b01, 1'b0);
    end
    step(1);
    chk("R2 full", 2'b10, 1'b0);
    cmd_on = 1'b0;
    step(1);
    chk("R7 release", 2'b00, 1'b0);
    settle_off();
  endtask

  task automatic t_blanking();
    cmd_on = 1'b1; desat = 1'b1;
    step(TB + 1);
    chk("R3 last blanked cycle", 2'b10, 1'b0);
    step(1);
    chk("R4 fault after blanking", 2'b01, 1'b1);
    cmd_on = 1'b0; desat = 1'b0;
    step(1);
    chk("R7 fault cancel", 2'b00, 1'b0);
    settle_off();
  endtask

  task automatic t_transient();
    cmd_on = 1'b1;
    step(TB + 4);
    desat = 1'b1;
    step(2);
    chk("R4 sync delay", 2'b10, 1'b0);
    step(1);
    chk("R4 fault entry", 2'b01, 1'b1);
    desat = 1'b0;
    step(TF - 1);
    chk("R5 last fault cycle", 2'b01, 1'b1);
    step(1);
    chk("R5 resume", 2'b10, 1'b0);
    settle_off();
  endtask

  task automatic t_persistent();
    cmd_on = 1'b1;
    step(TB + 4);
    desat = 1'b1;
    step(3);
    chk("R4 fault entry", 2'b01, 1'b1);
    step(TF - 1);
    chk("R6 last fault cycle", 2'b01, 1'b1);
    step(1);
    chk("R6 lockout entry", 2'b00, 1'b1);
    desat = 1'b0; cmd_on = 1'b0;
    step(5);
    chk("R6 lockout cmd low", 2'b00, 1'b1);
    cmd_on = 1'b1;
    step(5);
    chk("R6 lockout cmd ignored", 2'b00, 1'b1);
    step(LOCK - 11);
    chk("R6 last lockout cycle", 2'b00, 1'b1);
    step(1);
    chk("R6 lockout over", 2'b00, 1'b0);
    step(1);
    chk("R6 fresh plateau", 2'b01, 1'b0);
    settle_off();
  endtask

  task automatic t_enable();
    cmd_on = 1'b1;
    step(TB + 4);
    en_n = 1'b1;
    step(2);
    chk("R8 sync delay", 2'b10, 1'b0);
    step(1);
    chk("R8 disabled", 2'b00, 1'b0);
    step(5);
    chk("R8 cmd ignored", 2'b00, 1'b0);
    en_n = 1'b0;
    step(2);
    chk("R8 still off", 2'b00, 1'b0);
    step(1);
    chk("R8 restart", 2'b01, 1'b0);
    settle_off();
  endtask

  task automatic t_uvlo();
    cmd_on = 1'b1;
    step(TB + 4);
    desat = 1'b1;
    step(3);
    chk("R9 fault entry", 2'b01, 1'b1);
    uvlo = 1'b1;
    step(2);
    chk("R9 sync delay", 2'b01, 1'b1);
    step(1);
    chk("R9 undervoltage off", 2'b00, 1'b0);
    settle_off();
  endtask

  initial begin
    t_reset();
    t_turn_on();
    t_blanking();
    t_transient();
    t_persistent();
    t_enable();
    t_uvlo();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule